// File: doc/BRIEF.md
# Round-Robin Burst Egress Scheduler

This block drains packet data from several per-port receive FIFOs onto one shared 32-bit packet bus. It serves the ports in a fixed circular order. A port is passed over when it is disabled or its FIFO is empty. Each time a port is served, the block first puts that port's number on the data bus in a single select cycle. It then streams that port's words until one of two things happens: the configured burst length is reached, or the packet ends.

After every burst, the block can hold the bus idle for a programmable number of cycles before the next select cycle. Packet boundaries travel with the data on start and end strobes. A two-bit field tells how many trailing bytes of a packet's last word are unused. If the served FIFO runs dry in the middle of a burst, the block waits on that port with the valid strobe low. It does not switch to another port.

Top module: `rr_burst_sched`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rsx`, `rval`, `rsop`, `reop`, `rmod`, `rdat` and `fifo_rd` are all zero.
- R2: A port-select cycle has `rsx`=1 and `rval`=0, with the port number on `rdat` (upper bits zero). The FIFO of the selected port is read in the next cycle. When data is waiting, the first word therefore appears on the cycle right after the select cycle.
- R3: Data cycles have `rsx`=0 and `rval`=1. `rdat` carries the words of the most recently selected port's FIFO, in FIFO order. `rsx` and `rval` are never high together.
- R4: The search for the next port starts at the port after the one served last and wraps from port 3 to port 0. Right after reset, the search starts at port 0.
- R5: A port whose `port_en` bit is 0, or whose FIFO is empty at selection time, is skipped, and its FIFO is not read.
- R6: A burst holds at most 16 words when `burst_sel`=0 (64 bytes), 32 words when it is 1, and 64 words when it is 2 or 3. A packet longer than that is split. Its remainder is sent later, in a new burst with its own select cycle.
- R7: A burst ends after the word that carries the FIFO's end marker. `rsop` is 1 on a packet's first word and `reop` is 1 on its last word.
- R8: On the word where `reop` is 1, `rmod` equals the FIFO's trailing-unused-byte count (0 means all four bytes are valid). On every other cycle, `rmod` is 0.
- R9: After a burst's last word, exactly `gap_cycles` cycles pass with `rsx` and `rval` both 0 before the next select cycle, provided a port is eligible by then. With `gap_cycles`=0, the select cycle directly follows the last word.
- R10: If the served FIFO empties in the middle of a burst, `rval` is 0 until data returns. The burst then continues with the same port and no new select cycle.
- R11: While no port is eligible, `rsx` and `rval` are 0 and `rdat` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | NPORTS | Per-port enable |
| burst_sel | input | 2 | Burst length: 0=16, 1=32, 2 or 3=64 words |
| gap_cycles | input | GAP_W | Idle cycles after each burst |
| fifo_data | input | NPORTS*DW | Head word of each FIFO, port p at bits [p*DW +: DW] |
| fifo_empty | input | NPORTS | FIFO empty flags |
| fifo_sop | input | NPORTS | Head word begins a packet |
| fifo_eop | input | NPORTS | Head word ends a packet |
| fifo_mod | input | NPORTS*2 | Unused trailing bytes of head word, port p at [p*2 +: 2] |
| fifo_rd | output | NPORTS | Pop strobe per FIFO (show-ahead FIFOs) |
| rdat | output | DW | Bus data: port number or packet word |
| rsx | output | 1 | Port-select cycle |
| rval | output | 1 | Data word valid |
| rsop | output | 1 | Start of packet |
| reop | output | 1 | End of packet |
| rmod | output | 2 | Unused bytes in the last word |

## Verification
Single-port packets check the select-then-stream framing and the end-marker fields. Loading all four ports while they are disabled, then enabling them in one step, shows whether the rotation starts from the port after the last one served rather than from port 0. A mix of disabled, empty and loaded ports separates skipping from serving. Long packets at each length setting, and two long packets interleaved on two ports, show splitting and resumption across bursts. Gap settings of 0, 1 and 5 pin the pause to an exact cycle count. A packet pushed in two halves with a pause between them shows the block stalling on its port rather than re-selecting.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    typedef enum logic [1:0] {
        S_SEL  = 2'd0,
        S_DATA = 2'd1,
        S_GAP  = 2'd2
    } state_e;
endpackage

// File: rtl/rrs_rr_pick.sv
module rrs_rr_pick #(
    parameter int NPORTS = 4,
    localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic [NPORTS-1:0] req,
    input  logic [PW-1:0]     last,
    output logic              found,
    output logic [PW-1:0]     pick
);
    always_comb begin
        found = 1'b0;
        pick  = last;
        for (int i = 1; i <= NPORTS; i++) begin
            int k;
            k = (int'(last) + i) % NPORTS;
            if (!found && req[k]) begin
                found = 1'b1;
                pick  = PW'(k);
            end
        end
    end
endmodule

// File: rtl/rrs_port_mux.sv
module rrs_port_mux #(
    parameter int NPORTS = 4,
    parameter int DW     = 32,
    parameter int MODW   = 2,
    localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic [NPORTS*DW-1:0]   fifo_data,
    input  logic [NPORTS-1:0]      fifo_empty,
    input  logic [NPORTS-1:0]      fifo_sop,
    input  logic [NPORTS-1:0]      fifo_eop,
    input  logic [NPORTS*MODW-1:0] fifo_mod,
    input  logic [PW-1:0]          sel,
    input  logic                   rd_en,
    output logic [DW-1:0]          sel_data,
    output logic                   sel_empty,
    output logic                   sel_sop,
    output logic                   sel_eop,
    output logic [MODW-1:0]        sel_mod,
    output logic [NPORTS-1:0]      fifo_rd
);
    logic [DW-1:0]   dat_a [NPORTS];
    logic [MODW-1:0] mod_a [NPORTS];

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        assign dat_a[g]   = fifo_data[g*DW +: DW];
        assign mod_a[g]   = fifo_mod[g*MODW +: MODW];
        assign fifo_rd[g] = rd_en && (sel == PW'(g));
    end

    assign sel_data  = dat_a[sel];
    assign sel_mod   = mod_a[sel];
    assign sel_empty = fifo_empty[sel];
    assign sel_sop   = fifo_sop[sel];
    assign sel_eop   = fifo_eop[sel];
endmodule

// File: rtl/rrs_burst_limit.sv
module rrs_burst_limit #(
    parameter int BASE_BYTES = 64,
    parameter int BPW        = 4,
    parameter int CW         = 7
) (
    input  logic [1:0]    burst_sel,
    output logic [CW-1:0] max_words
);
    localparam int W1 = BASE_BYTES / BPW;

    always_comb begin
        case (burst_sel)
            2'd0:    max_words = CW'(W1);
            2'd1:    max_words = CW'(2 * W1);
            default: max_words = CW'(4 * W1);
        endcase
    end
endmodule

// File: rtl/rr_burst_sched.sv
module rr_burst_sched
    import rrs_pkg::*;
#(
    parameter int NPORTS     = 4,
    parameter int DW         = 32,
    parameter int GAP_W      = 8,
    parameter int BASE_BYTES = 64,
    localparam int PW   = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int BPW  = DW / 8,
    localparam int MODW = $clog2(BPW),
    localparam int MAXW = 4 * BASE_BYTES / BPW,
    localparam int CW   = $clog2(MAXW + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPORTS-1:0]      port_en,
    input  logic [1:0]             burst_sel,
    input  logic [GAP_W-1:0]       gap_cycles,
    input  logic [NPORTS*DW-1:0]   fifo_data,
    input  logic [NPORTS-1:0]      fifo_empty,
    input  logic [NPORTS-1:0]      fifo_sop,
    input  logic [NPORTS-1:0]      fifo_eop,
    input  logic [NPORTS*MODW-1:0] fifo_mod,
    output logic [NPORTS-1:0]      fifo_rd,
    output logic [DW-1:0]          rdat,
    output logic                   rsx,
    output logic                   rval,
    output logic                   rsop,
    output logic                   reop,
    output logic [MODW-1:0]        rmod
);
    typedef struct packed {
        state_e           st;
        logic [PW-1:0]    cur;
        logic [PW-1:0]    last;
        logic [CW-1:0]    cnt;
        logic [GAP_W-1:0] gap;
        logic [DW-1:0]    dat;
        logic             sx;
        logic             val;
        logic             sop;
        logic             eop;
        logic [MODW-1:0]  mod;
    } regs_t;

    regs_t r_d, r_q;

    logic [NPORTS-1:0] req;
    logic              found;
    logic [PW-1:0]     pick;
    logic [DW-1:0]     sel_data;
    logic              sel_empty, sel_sop, sel_eop;
    logic [MODW-1:0]   sel_mod;
    logic              rd_en;
    logic [CW-1:0]     max_words;
    logic [CW-1:0]     cnt_inc;

    assign req = port_en & ~fifo_empty;

    rrs_rr_pick #(.NPORTS(NPORTS)) i_pick (
        .req   (req),
        .last  (r_q.last),
        .found (found),
        .pick  (pick)
    );

    rrs_port_mux #(.NPORTS(NPORTS), .DW(DW), .MODW(MODW)) i_mux (
        .fifo_data  (fifo_data),
        .fifo_empty (fifo_empty),
        .fifo_sop   (fifo_sop),
        .fifo_eop   (fifo_eop),
        .fifo_mod   (fifo_mod),
        .sel        (r_q.cur),
        .rd_en      (rd_en),
        .sel_data   (sel_data),
        .sel_empty  (sel_empty),
        .sel_sop    (sel_sop),
        .sel_eop    (sel_eop),
        .sel_mod    (sel_mod),
        .fifo_rd    (fifo_rd)
    );

    rrs_burst_limit #(.BASE_BYTES(BASE_BYTES), .BPW(BPW), .CW(CW)) i_limit (
        .burst_sel (burst_sel),
        .max_words (max_words)
    );

    always_comb begin
        r_d     = r_q;
        r_d.sx  = 1'b0;
        r_d.val = 1'b0;
        r_d.sop = 1'b0;
        r_d.eop = 1'b0;
        r_d.mod = '0;
        r_d.dat = '0;
        rd_en   = 1'b0;
        cnt_inc = r_q.cnt + 1'b1;
        case (r_q.st)
            S_SEL: begin
                if (found) begin
                    r_d.cur  = pick;
                    r_d.last = pick;
                    r_d.cnt  = '0;
                    r_d.sx   = 1'b1;
                    r_d.dat  = {{(DW-PW){1'b0}}, pick};
                    r_d.st   = S_DATA;
                end
            end
            S_DATA: begin
                if (!sel_empty) begin
                    rd_en   = 1'b1;
                    r_d.val = 1'b1;
                    r_d.dat = sel_data;
                    r_d.sop = sel_sop;
                    r_d.eop = sel_eop;
                    r_d.mod = sel_eop ? sel_mod : '0;
                    r_d.cnt = cnt_inc;
                    if (sel_eop || cnt_inc == max_words) begin
                        if (gap_cycles == '0) begin
                            r_d.st = S_SEL;
                        end else begin
                            r_d.st  = S_GAP;
                            r_d.gap = gap_cycles - 1'b1;
                        end
                    end
                end
            end
            S_GAP: begin
                if (r_q.gap == '0) r_d.st = S_SEL;
                else               r_d.gap = r_q.gap - 1'b1;
            end
            default: r_d.st = S_SEL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= S_SEL;
            r_q.last <= PW'(NPORTS - 1);
        end else begin
            r_q <= r_d;
        end
    end

    assign rdat = r_q.dat;
    assign rsx  = r_q.sx;
    assign rval = r_q.val;
    assign rsop = r_q.sop;
    assign reop = r_q.eop;
    assign rmod = r_q.mod;
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
    parameter int NPORTS     = 4,
    parameter int DW         = 32,
    parameter int BASE_BYTES = 64,
    localparam int PW   = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int MODW = $clog2(DW / 8)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPORTS-1:0] port_en,
    input logic [1:0]        burst_sel,
    input logic [NPORTS-1:0] fifo_empty,
    input logic [NPORTS-1:0] fifo_rd,
    input logic [DW-1:0]     rdat,
    input logic              rsx,
    input logic              rval,
    input logic              rsop,
    input logic              reop,
    input logic [MODW-1:0]   rmod
);
    logic [NPORTS-1:0] en_q, empty_q;
    int                wcnt;
    int                limit;

    assign limit = (BASE_BYTES / (DW / 8)) << ((burst_sel == 2'd3) ? 2 : int'(burst_sel));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            empty_q <= '1;
            wcnt    <= 0;
        end else begin
            en_q    <= port_en;
            empty_q <= fifo_empty;
            if (rsx)       wcnt <= 0;
            else if (rval) wcnt <= wcnt + 1;
        end
    end

    // R3
    sx_val_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsx && rval));

    // R2
    sel_port_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsx |-> (rdat < DW'(NPORTS)));

    // R2
    sel_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsx |=> !rsx);

    // R5
    sel_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsx |-> (en_q[rdat[PW-1:0]] && !empty_q[rdat[PW-1:0]]));

    // R10
    no_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fifo_rd & fifo_empty) == '0) && $onehot0(fifo_rd));

    // R8
    mod_on_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rmod != '0) |-> reop);

    // R7
    markers_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsop || reop) |-> rval);

    // R6
    burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rval |-> (wcnt < limit));

    // R11
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsx && !rval) |-> (rdat == '0));
endmodule

bind rr_burst_sched rrs_checker #(
    .NPORTS(NPORTS), .DW(DW), .BASE_BYTES(BASE_BYTES)
) i_rrs_checker (.*);

// File: tb/test_rr_burst_sched.sv
`timescale 1ns/1ps
module test_rr_burst_sched;
    localparam int N = 4, DW = 32, GW = 8, DEPTH = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [N-1:0]    port_en = '0;
    logic [1:0]      burst_sel = 2'd0;
    logic [GW-1:0]   gap_cycles = '0;
    logic [N*DW-1:0] fifo_data;
    logic [N-1:0]    fifo_empty, fifo_sop, fifo_eop, fifo_rd;
    logic [N*2-1:0]  fifo_mod;
    logic [DW-1:0]   rdat;
    logic            rsx, rval, rsop, reop;
    logic [1:0]      rmod;

    rr_burst_sched i_rr_burst_sched (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .burst_sel(burst_sel),
        .gap_cycles(gap_cycles), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
        .fifo_sop(fifo_sop), .fifo_eop(fifo_eop), .fifo_mod(fifo_mod),
        .fifo_rd(fifo_rd), .rdat(rdat), .rsx(rsx), .rval(rval), .rsop(rsop),
        .reop(reop), .rmod(rmod)
    );

    // Expected items: written by the driver, read by the FIFO model and the monitor
    logic [DW-1:0] m_dat [N][DEPTH];
    bit            m_sop [N][DEPTH];
    bit            m_eop [N][DEPTH];
    logic [1:0]    m_mod [N][DEPTH];
    int            wp [N] = '{default: 0};
    int            rp [N] = '{default: 0};

    always_comb begin
        for (int p = 0; p < N; p++) begin
            fifo_empty[p]         = (rp[p] >= wp[p]);
            fifo_data[p*DW +: DW] = m_dat[p][rp[p]];
            fifo_sop[p]           = m_sop[p][rp[p]];
            fifo_eop[p]           = m_eop[p][rp[p]];
            fifo_mod[p*2 +: 2]    = m_mod[p][rp[p]];
        end
    end

    always @(posedge clk) begin
        for (int p = 0; p < N; p++)
            if (fifo_rd[p] && rp[p] < wp[p]) rp[p] <= rp[p] + 1;
    end

    int tb_checks = 0, tb_fails = 0, mon_checks = 0, mon_fails = 0;
    int seqn = 0;

    function automatic int exp_words(logic [1:0] s);
        return 16 << ((s == 2'd3) ? 2 : int'(s));
    endfunction

    // Monitor: rebuilds bursts from the bus and compares each word
    typedef struct { int port; int nw; int gap; int lead; } rec_t;
    rec_t recs[$];
    int   mrp [N] = '{default: 0};
    bit   open = 1'b0;
    int   cur = 0, nw = 0, idle = 0, since = 0, lead = 0, gapb = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            mon_checks++;
            if (rsx && rval) begin
                mon_fails++;
                $display("FAIL R3: rsx and rval both high (act 1/1, exp not both)");
            end else if (rsx) begin
                if (open) begin
                    mon_fails++;
                    $display("FAIL R10: new select while burst open (act port %0d, exp continue port %0d)", rdat, cur);
                end
                if (rdat >= N) begin
                    mon_fails++;
                    $display("FAIL R2: select port act %0d exp < %0d", rdat, N);
                end
                cur = int'(rdat % N); open = 1'b1; nw = 0; gapb = idle; since = 0; lead = -1;
            end else if (rval) begin
                if (!open) begin
                    mon_fails++;
                    $display("FAIL R3: data word %h without open burst (exp select first)", rdat);
                end else if (mrp[cur] >= wp[cur]) begin
                    mon_fails++;
                    $display("FAIL R3: extra word %h on port %0d (exp none)", rdat, cur);
                end else begin
                    automatic int i = mrp[cur];
                    automatic logic [1:0] em = m_eop[cur][i] ? m_mod[cur][i] : 2'd0;
                    if (rdat !== m_dat[cur][i] || rsop !== m_sop[cur][i] ||
                        reop !== m_eop[cur][i] || rmod !== em) begin
                        mon_fails++;
                        $display("FAIL R3/R7/R8: port %0d act %h s%0d e%0d m%0d exp %h s%0d e%0d m%0d",
                                 cur, rdat, rsop, reop, rmod, m_dat[cur][i], m_sop[cur][i],
                                 m_eop[cur][i], em);
                    end
                    mrp[cur]++;
                    if (lead < 0) lead = since;
                    nw++;
                    if (m_eop[cur][i] || nw == exp_words(burst_sel)) begin
                        recs.push_back('{cur, nw, gapb, lead});
                        open = 1'b0; idle = 0;
                    end
                end
            end else begin
                idle++;
                if (open) since++;
                if (rdat !== '0 || rsop || reop || rmod !== 2'd0) begin
                    mon_fails++;
                    $display("FAIL R11: idle bus act rdat=%h sop=%0d eop=%0d mod=%0d exp all 0",
                             rdat, rsop, reop, rmod);
                end
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        tb_checks++;
        if (act != exp) begin
            tb_fails++;
            $display("FAIL %s: act %0d exp %0d", tag, act, exp);
        end
    endtask

    task automatic push_words(int p, int n, bit first_sop, bit last_eop, logic [1:0] md);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            m_dat[p][wp[p] + i] = {8'(p + 8'hA0), 24'(seqn)};
            seqn++;
            m_sop[p][wp[p] + i] = first_sop && (i == 0);
            m_eop[p][wp[p] + i] = last_eop && (i == n - 1);
            m_mod[p][wp[p] + i] = (last_eop && i == n - 1) ? md : 2'd0;
        end
        wp[p] = wp[p] + n;
    endtask

    task automatic push_pkt(int p, int n, logic [1:0] md);
        push_words(p, n, 1'b1, 1'b1, md);
    endtask

    task automatic drain();
        bit done = 1'b0;
        for (int t = 0; t < 3000 && !done; t++) begin
            @(negedge clk);
            done = !open;
            for (int p = 0; p < N; p++)
                if (port_en[p] && rp[p] < wp[p]) done = 1'b0;
        end
        repeat (int'(gap_cycles) + 4) @(negedge clk);
    endtask

    task automatic check_rec(string tag, int idx, int port, int n);
        if (idx >= recs.size()) begin
            check({tag, " burst missing"}, recs.size(), idx + 1);
        end else begin
            check({tag, " port"}, recs[idx].port, port);
            check({tag, " words"}, recs[idx].nw, n);
        end
    endtask

    task automatic summary();
        int total;
        int bad;
        total = tb_checks + mon_checks;
        bad   = tb_fails + mon_fails;
        $display("%0d/%0d checks passed", total - bad, total);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tb_fails++; tb_checks++;
        $display("FAIL watchdog: act timeout exp completion");
        summary();
        $finish;
    end

    initial begin
        int b;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", int'({rsx, rval, rsop, reop, rmod, fifo_rd}), 0);
        check("R1 rdat in reset", int'(rdat), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first cycle after reset", int'({rsx, rval, rsop, reop, rmod, fifo_rd}), 0);
        // R11: no eligible port, bus idle
        port_en = '1;
        repeat (8) @(negedge clk);
        check("R11 idle no data", int'({rsx, rval, rdat}), 0);
        check("R11 no bursts", recs.size(), 0);

        // R2 R7 R8: single packet on port 2
        b = recs.size();
        push_pkt(2, 5, 2'd3);
        drain();
        check_rec("R2 single", b, 2, 5);
        check("R2 first word right after select", recs[b].lead, 0);

        // R4: all loaded while disabled; search starts after port 2
        port_en = '0;
        b = recs.size();
        for (int p = 0; p < N; p++) push_pkt(p, 3, 2'(p));
        @(negedge clk); port_en = '1;
        drain();
        check_rec("R4 rot0", b,     3, 3);
        check_rec("R4 rot1", b + 1, 0, 3);
        check_rec("R4 rot2", b + 2, 1, 3);
        check_rec("R4 rot3", b + 3, 2, 3);

        // R5: port 1 disabled, port 3 empty
        port_en = '0;
        b = recs.size();
        push_pkt(0, 2, 2'd1);
        push_pkt(1, 2, 2'd2);
        push_pkt(2, 2, 2'd0);
        @(negedge clk); port_en = 4'b1101;
        drain();
        check_rec("R5 skip a", b,     0, 2);
        check_rec("R5 skip b", b + 1, 2, 2);
        check("R5 bursts while port1 off", recs.size() - b, 2);
        check("R5 disabled FIFO untouched", wp[1] - rp[1], 2);
        port_en = '1;
        drain();
        check_rec("R5 re-enabled", b + 2, 1, 2);

        // R6: burst length per setting, single port 0
        for (int s = 0; s < 4; s++) begin
            automatic int len = (s < 2) ? 40 : 70;
            automatic int w = exp_words(2'(s));
            burst_sel = 2'(s);
            b = recs.size();
            push_pkt(0, len, 2'd1);
            drain();
            for (int k = 0; k * w < len; k++)
                check_rec($sformatf("R6 sel%0d burst%0d", s, k), b + k, 0,
                          ((len - k * w) < w) ? (len - k * w) : w);
            check($sformatf("R9 sel%0d no gap", s), recs[b + 1].gap, 0);
        end

        // R6 R4: two long packets interleaved, last served was 0
        burst_sel = 2'd0;
        port_en = '0;
        b = recs.size();
        push_pkt(0, 20, 2'd0);
        push_pkt(1, 20, 2'd3);
        @(negedge clk); port_en = '1;
        drain();
        check_rec("R6 split a", b,     1, 16);
        check_rec("R6 split b", b + 1, 0, 16);
        check_rec("R6 split c", b + 2, 1, 4);
        check_rec("R6 split d", b + 3, 0, 4);

        // R9: pause of 5 and of 1
        gap_cycles = 8'd5;
        port_en = '0;
        b = recs.size();
        push_pkt(1, 2, 2'd0);
        push_pkt(1, 2, 2'd2);
        @(negedge clk); port_en = '1;
        drain();
        check_rec("R9 gap5 b", b + 1, 1, 2);
        check("R9 gap5 idle count", recs[b + 1].gap, 5);
        gap_cycles = 8'd1;
        port_en = '0;
        b = recs.size();
        push_pkt(2, 3, 2'd1);
        push_pkt(2, 1, 2'd3);
        @(negedge clk); port_en = '1;
        drain();
        check_rec("R9 gap1 b", b + 1, 2, 1);
        check("R9 gap1 idle count", recs[b + 1].gap, 1);

        // R10: FIFO runs dry mid-burst
        gap_cycles = 8'd0;
        b = recs.size();
        push_words(3, 3, 1'b1, 1'b0, 2'd0);
        repeat (10) @(negedge clk);
        check("R10 stalled rval low", int'({rsx, rval}), 0);
        push_words(3, 3, 1'b0, 1'b1, 2'd2);
        drain();
        check_rec("R10 one burst", b, 3, 6);
        check("R10 no reselect", recs.size() - b, 1);

        summary();
        $finish;
    end
endmodule